// File: doc/BRIEF.md
# NRZ Serial Byte Receiver

This block takes a non-return-to-zero data stream one bit at a time and packs it into bytes for a host. A programmable divider turns the system clock into a bit-period strobe, and the incoming level is sampled exactly once per period. Every eighth sample completes a byte. The completed byte is copied into a holding register that the host can read, and a byte-ready interrupt is raised.

The block does not search for byte or word alignment. Bits are grouped in eights, counting from the moment the receiver is enabled, and the host does all framing. The earliest bit of each byte lands in the most significant position.

If the host is slow, the holding register is given up at the eighth bit of the following byte. At that point an overrun interrupt is raised and the unread byte is replaced by the newer one. A general soft reset clears the flags and any partial byte, but leaves the holding register as it was.

Top module: `nrz_byte_rx`

## Requirements
- R1: When the eighth sample of a byte is taken, `byteReadyIrq` is 1 from the next clock, and `rxByte` holds the assembled byte.
- R2: The first bit sampled after enable (or after the previous byte) occupies bit 7 of `rxByte`, and the last bit occupies bit 0.
- R3: One bit period lasts `baudDiv`+1 clock cycles. Counting from the clock edge at which the receiver becomes enabled, the eighth sample is taken on edge 8×(`baudDiv`+1).
- R4: A `hostRead` pulse clears `byteReadyIrq` on the following clock, unless a byte completes in the same cycle. `rxByte` is left unchanged.
- R5: If `byteReadyIrq` is still 1 when the eighth bit of the next byte is sampled, `overrunIrq` becomes 1 and `rxByte` takes the newer byte, discarding the unread one.
- R6: An `overrunAck` pulse clears `overrunIrq` and does not change `byteReadyIrq`.
- R7: When a host read and a byte completion fall in the same cycle, `byteReadyIrq` stays 1 and no overrun is raised.
- R8: While `rxEnable` is 0, the bit position is held at zero, and any partial byte is dropped. After enable, packing restarts from a fresh byte.
- R9: A `softRst` pulse clears both interrupt flags and the partial byte, and does not alter `rxByte`.
- R10: After power-up reset, both flags are 0 and `rxByte` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| softRst | input | 1 | General soft reset; clears flags and partial byte |
| rxEnable | input | 1 | Receiver enable |
| baudDiv | input | DIV_W | Bit period minus one, in clock cycles (shared rate setting) |
| rxBit | input | 1 | Sliced NRZ data bit |
| hostRead | input | 1 | Host read strobe for the holding register |
| overrunAck | input | 1 | Host acknowledge clearing the overrun flag |
| rxByte | output | BYTE_W | Holding register, first bit in the MSB |
| byteReadyIrq | output | 1 | Byte-ready interrupt flag |
| overrunIrq | output | 1 | Overrun interrupt flag |

## Verification
A byte completion and the host read that clears the ready flag can land on the same clock edge. The bench provokes this by raising `hostRead` for exactly the cycle that holds the eighth sampling edge of a byte that follows an unread one. It then expects the ready flag to stay set, the overrun flag to stay clear, and the new byte to be held. The opposite timing is also exercised: with no read before the eighth bit of the next byte, the overrun fires and the newer byte replaces the older one.

// File: rtl/nrz_rx_pkg.sv
package nrz_rx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic sample;  // take one bit this cycle
    logic load;    // byte complete: copy into holding register
    logic flush;   // drop partial byte
  } rxStrobes_t;
endpackage

// File: rtl/nrz_rx_baud.sv
module nrz_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] baudDiv,
  output logic             tick
);
  logic [DIV_W-1:0] periodCnt;
  logic             periodEnd;

  // >= keeps the period bounded if the divider shrinks mid-count
  assign periodEnd = (periodCnt >= baudDiv);
  assign tick      = run && periodEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         periodCnt <= '0;
    else if (!run)      periodCnt <= '0;
    else if (periodEnd) periodCnt <= '0;
    else                periodCnt <= periodCnt + 1'b1;
  end
endmodule

// File: rtl/nrz_rx_ctrl.sv
module nrz_rx_ctrl
  import nrz_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             softRst,
  input  logic             tick,
  input  logic             hostRead,
  input  logic             overrunAck,
  output rxStrobes_t       strobes,
  output logic [CNT_W-1:0] bitCnt,
  output logic             readyFlag,
  output logic             overrunFlag
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic byteDone;
  assign byteDone = tick && (bitCnt == LAST_IDX);

  always_comb begin
    strobes.sample = tick;
    strobes.load   = byteDone;
    strobes.flush  = !run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bitCnt <= '0;
    else if (!run)     bitCnt <= '0;
    else if (byteDone) bitCnt <= '0;
    else if (tick)     bitCnt <= bitCnt + 1'b1;
  end

  // a completion beats a read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        readyFlag <= 1'b0;
    else if (softRst)  readyFlag <= 1'b0;
    else if (byteDone) readyFlag <= 1'b1;
    else if (hostRead) readyFlag <= 1'b0;
  end

  // a new overrun beats an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  overrunFlag <= 1'b0;
    else if (softRst)                            overrunFlag <= 1'b0;
    else if (byteDone && readyFlag && !hostRead) overrunFlag <= 1'b1;
    else if (overrunAck)                         overrunFlag <= 1'b0;
  end
endmodule

// File: rtl/nrz_rx_datapath.sv
module nrz_rx_datapath
  import nrz_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxStrobes_t        strobes,
  input  logic              rxBit,
  output logic [BYTE_W-1:0] rxByte
);
  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] nextWord;

  // earliest bit ends up in the MSB
  assign nextWord = {shiftReg, rxBit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              shiftReg <= '0;
    else if (strobes.flush)  shiftReg <= '0;
    else if (strobes.sample) shiftReg <= nextWord[BYTE_W-2:0];
  end

  // holding register: only power-up reset and completed bytes touch it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rxByte <= '0;
    else if (strobes.load) rxByte <= nextWord;
  end
endmodule

// File: rtl/nrz_byte_rx.sv
module nrz_byte_rx
  import nrz_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 16,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softRst,
  input  logic              rxEnable,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              rxBit,
  input  logic              hostRead,
  input  logic              overrunAck,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteReadyIrq,
  output logic              overrunIrq
);
  rxStrobes_t       strobes;
  logic             run;
  logic             tick;
  logic [CNT_W-1:0] bitCnt;

  assign run = rxEnable && !softRst;

  nrz_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .baudDiv(baudDiv), .tick(tick)
  );

  nrz_rx_ctrl #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .softRst(softRst), .tick(tick),
    .hostRead(hostRead), .overrunAck(overrunAck), .strobes(strobes),
    .bitCnt(bitCnt), .readyFlag(byteReadyIrq), .overrunFlag(overrunIrq)
  );

  nrz_rx_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rxBit(rxBit), .rxByte(rxByte)
  );
endmodule

// File: rtl/nrz_rx_checker.sv
module nrz_rx_checker #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              softRst,
  input logic              rxEnable,
  input logic              hostRead,
  input logic              overrunAck,
  input logic              tick,
  input logic [CNT_W-1:0]  bitCnt,
  input logic [BYTE_W-1:0] rxByte,
  input logic              byteReadyIrq,
  input logic              overrunIrq
);
  logic lastTick;
  assign lastTick = tick && (bitCnt == CNT_W'(BYTE_W - 1));

  p_ready_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lastTick && !softRst) |=> byteReadyIrq);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRead && !lastTick) |=> !byteReadyIrq);

  p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lastTick && byteReadyIrq && !hostRead && !softRst) |=> overrunIrq);

  p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrunIrq) |-> $past(tick));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrunAck && !lastTick) |=> !overrunIrq);

  p_collision_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lastTick && hostRead && !softRst) |=> (byteReadyIrq && !$rose(overrunIrq)));

  p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> (bitCnt == '0));

  p_soft_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |=> ($stable(rxByte) && !byteReadyIrq && !overrunIrq));
endmodule

bind nrz_byte_rx nrz_rx_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .softRst(softRst), .rxEnable(rxEnable),
  .hostRead(hostRead), .overrunAck(overrunAck), .tick(tick), .bitCnt(bitCnt),
  .rxByte(rxByte), .byteReadyIrq(byteReadyIrq), .overrunIrq(overrunIrq)
);

// File: tb/tb_nrz_byte_rx.sv
module tb_nrz_byte_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BAUD_DIV   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        softRst = 1'b0;
  logic        rxEnable = 1'b0;
  logic [15:0] baudDiv = 16'(BAUD_DIV);
  logic        rxBit = 1'b0;
  logic        hostRead = 1'b0;
  logic        overrunAck = 1'b0;
  logic [7:0]  rxByte;
  logic        byteReadyIrq;
  logic        overrunIrq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nrz_byte_rx dut (
    .clk(clk), .rst_n(rst_n), .softRst(softRst), .rxEnable(rxEnable),
    .baudDiv(baudDiv), .rxBit(rxBit), .hostRead(hostRead),
    .overrunAck(overrunAck), .rxByte(rxByte), .byteReadyIrq(byteReadyIrq),
    .overrunIrq(overrunIrq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // msb-first bits, each held one full bit period; optional read on last edge
  task automatic sendBits(input logic [7:0] v, input int n, input bit readAtEnd);
    for (int i = 0; i < n; i++) begin
      rxBit = v[7-i];
      if (readAtEnd && i == n - 1) begin
        repeat (BAUD_DIV) @(negedge clk);
        hostRead = 1'b1;
        @(negedge clk);
        hostRead = 1'b0;
      end else begin
        repeat (BAUD_DIV + 1) @(negedge clk);
      end
    end
  endtask

  task automatic restart();
    rxEnable = 1'b0; hostRead = 1'b1; overrunAck = 1'b1;
    @(negedge clk);
    hostRead = 1'b0; overrunAck = 1'b0; rxEnable = 1'b1;
  endtask

  task automatic t_reset();
    check(byteReadyIrq == 1'b0, "R10 ready", 32'(byteReadyIrq), 0);
    check(overrunIrq == 1'b0, "R10 overrun", 32'(overrunIrq), 0);
    check(rxByte == 8'h00, "R10 rxByte", 32'(rxByte), 0);
  endtask

  task automatic t_basic();
    restart();
    sendBits(8'hB2, 8, 1'b0);
    check(byteReadyIrq == 1'b1, "R1 ready", 32'(byteReadyIrq), 1);
    check(rxByte == 8'hB2, "R2 order", 32'(rxByte), 32'hB2);
    check(overrunIrq == 1'b0, "R1 no overrun", 32'(overrunIrq), 0);
    hostRead = 1'b1; @(negedge clk); hostRead = 1'b0;
    check(byteReadyIrq == 1'b0, "R4 read clears", 32'(byteReadyIrq), 0);
    check(rxByte == 8'hB2, "R4 byte kept", 32'(rxByte), 32'hB2);
  endtask

  task automatic t_timing();
    restart();
    sendBits(8'h80, 7, 1'b0);
    rxBit = 1'b1;
    repeat (BAUD_DIV) @(negedge clk);
    check(byteReadyIrq == 1'b0, "R3 not early", 32'(byteReadyIrq), 0);
    @(negedge clk);
    check(byteReadyIrq == 1'b1, "R3 on time", 32'(byteReadyIrq), 1);
    check(rxByte == 8'h81, "R3 byte", 32'(rxByte), 32'h81);
  endtask

  task automatic t_overrun();
    restart();
    sendBits(8'h3C, 8, 1'b0);
    sendBits(8'hC3, 7, 1'b0);
    check(overrunIrq == 1'b0, "R5 no overrun before 8th bit", 32'(overrunIrq), 0);
    check(rxByte == 8'h3C, "R5 old byte held", 32'(rxByte), 32'h3C);
    rxBit = 1'b1;
    repeat (BAUD_DIV + 1) @(negedge clk);
    check(overrunIrq == 1'b1, "R5 overrun", 32'(overrunIrq), 1);
    check(rxByte == 8'hC3, "R5 newer byte", 32'(rxByte), 32'hC3);
    check(byteReadyIrq == 1'b1, "R5 ready", 32'(byteReadyIrq), 1);
    overrunAck = 1'b1; @(negedge clk); overrunAck = 1'b0;
    check(overrunIrq == 1'b0, "R6 ack clears", 32'(overrunIrq), 0);
    check(byteReadyIrq == 1'b1, "R6 ready untouched", 32'(byteReadyIrq), 1);
  endtask

  task automatic t_collision();
    restart();
    sendBits(8'h55, 8, 1'b0);
    sendBits(8'h9A, 8, 1'b1);
    check(byteReadyIrq == 1'b1, "R7 ready kept", 32'(byteReadyIrq), 1);
    check(overrunIrq == 1'b0, "R7 no overrun", 32'(overrunIrq), 0);
    check(rxByte == 8'h9A, "R7 byte", 32'(rxByte), 32'h9A);
  endtask

  task automatic t_disable();
    restart();
    sendBits(8'hFF, 5, 1'b0);
    rxEnable = 1'b0;
    repeat (3) @(negedge clk);
    check(byteReadyIrq == 1'b0, "R8 no byte while idle", 32'(byteReadyIrq), 0);
    check(rxByte == 8'h9A, "R8 holding unchanged", 32'(rxByte), 32'h9A);
    rxEnable = 1'b1;
    sendBits(8'hA5, 8, 1'b0);
    check(rxByte == 8'hA5, "R8 fresh grouping", 32'(rxByte), 32'hA5);
  endtask

  task automatic t_soft();
    restart();
    sendBits(8'h6E, 8, 1'b0);
    sendBits(8'h11, 3, 1'b0);
    softRst = 1'b1; @(negedge clk); softRst = 1'b0;
    check(byteReadyIrq == 1'b0, "R9 ready cleared", 32'(byteReadyIrq), 0);
    check(overrunIrq == 1'b0, "R9 overrun cleared", 32'(overrunIrq), 0);
    check(rxByte == 8'h6E, "R9 holding kept", 32'(rxByte), 32'h6E);
    sendBits(8'hD4, 8, 1'b0);
    check(rxByte == 8'hD4, "R9 restart grouping", 32'(rxByte), 32'hD4);
    check(overrunIrq == 1'b0, "R9 no overrun", 32'(overrunIrq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_timing();
    t_overrun();
    t_collision();
    t_disable();
    t_soft();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule